// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Controller

This block turns a set of external interrupt pins into delivery requests for a downstream interrupt fabric. Software reaches every internal register through two bus locations: a select location that holds an internal index, and a data window that reads or writes whichever register that index names. Behind the window sit an identification register, a read-only version register, an arbitration register and a table with one 64-bit routing entry per pin. Each entry holds the vector, the delivery mode, the destination mode, the destination ID, the pin's polarity, its trigger mode and a mask bit. Each 64-bit entry is reached as two 32-bit halves.

Each pin is first corrected for polarity. It is then handled as an edge source or as a level source, as its entry selects. A pin that fires presents a request on a valid/accept handshake. The request carries the vector, the delivery mode, the destination mode and the destination ID. Level-mode pins set a remote-IRR flag when their request is accepted. That flag blocks further requests from the pin until an end-of-interrupt with a matching vector arrives. When several pins have requests at the same time, the lowest-numbered one goes out first.

Top module: `irq_redirect_unit`

## Requirements
- R1: A bus write to address 0x00 loads the 8-bit select register, and a read there returns it in bits 7:0. Address 0x10 is the data window onto the selected register. Any other bus address reads as zero.
- R2: Index 0x01 reads the version word: implementation version 0x11 in bits 7:0 and the number of pins minus one (23 by default) in bits 23:16. Index 0x00 holds a 4-bit unit ID in bits 27:24, which software can write. Index 0x02 reads that same ID in bits 27:24.
- R3: After reset, the low half of every entry reads 0x00010000 (only the mask bit is set) and the high half reads zero.
- R4: Entry n sits at index 0x10+2n (low half) and 0x11+2n (high half). The low half has vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13 (1 = active low), remote IRR 14, trigger 15 (1 = level) and mask 16. The high half has the destination ID in bits 31:24. A write to one half leaves the other half unchanged, and unused bits read as zero.
- R5: Writes to the delivery-status and remote-IRR bits have no effect. An index that names no register (such as 0x03, or one past the last entry) reads zero and ignores writes.
- R6: A masked pin raises no request. An edge that occurs while the pin is masked is discarded and is not delivered when the pin is later unmasked.
- R7: In edge mode, each inactive-to-active transition produces exactly one request. The request carries the entry's vector, delivery mode, destination mode and destination ID.
- R8: With polarity set to active low, a falling pin is the active transition and a rising pin raises nothing.
- R9: In level mode, an active pin with remote IRR clear raises a request, and acceptance sets remote IRR. An end-of-interrupt whose vector matches clears remote IRR, after which a pin that is still active requests again. A non-matching vector leaves remote IRR set.
- R10: Of the pins with requests at the same time, the lowest-numbered one is presented first. Only one request is outstanding at a time, and it holds steady until it is accepted.
- R11: Delivery status (bit 12) reads 1 while a pin's request is raised and not yet accepted, and 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Bus byte address (0x00 select, 0x10 window) |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, combinational |
| irq_pins | input | NPINS | Interrupt input pins |
| req_valid | output | 1 | Delivery request valid |
| req_accept | input | 1 | Downstream accepts the request |
| req_vector | output | 8 | Request vector |
| req_dmode | output | 3 | Request delivery mode |
| req_dlogical | output | 1 | Request destination mode (1 = logical) |
| req_dest | output | 8 | Request destination ID |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by end-of-interrupt |

## Verification
A window write takes effect at the next clock edge. Reads are combinational, so the bench samples them just after it places the address. An edge-mode request appears two rising edges after the pin changes: one edge latches it as pending and the next grants it. A level-mode request appears after a single edge. After an accept, req_valid drops at the next edge, and a waiting pin is granted one edge later. After a matching end-of-interrupt, a still-active level pin requests again two edges later. The bench drives and samples only at falling edges and counts those edges exactly, so it checks req_valid both one cycle early, where it must still be low, and at its due cycle.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

    // Writable fields of one routing entry (status bits live in the pin slice)
    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       trig;    // 1 = level
        logic       pol;     // 1 = active low
        logic       dlog;    // 1 = logical destination
        logic [2:0] dmode;
        logic [7:0] vector;
    } entry_cfg_t;

    localparam logic [7:0] ADDR_SEL = 8'h00;
    localparam logic [7:0] ADDR_WIN = 8'h10;

    localparam logic [7:0] IDX_ID   = 8'h00;
    localparam logic [7:0] IDX_VER  = 8'h01;
    localparam logic [7:0] IDX_ARB  = 8'h02;
    localparam logic [7:0] IDX_TBL  = 8'h10;

endpackage

// File: rtl/irq_pin_slice.sv
module irq_pin_slice
    import irq_redir_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_in,
    input  entry_cfg_t cfg,
    input  logic       grant_ack,
    input  logic       eoi_valid,
    input  logic [7:0] eoi_vector,
    output logic       req_line,
    output logic       dstat,
    output logic       rirr
);

    typedef struct packed {
        logic prev_act;
        logic pending;
        logic rirr;
    } slice_state_t;

    slice_state_t st_d, st_q;
    logic active;
    logic unused_fields;

    assign unused_fields = ^{cfg.dest, cfg.dmode, cfg.dlog};

    always_comb begin
        st_d     = st_q;
        active   = pin_in ^ cfg.pol;
        st_d.prev_act = active;
        req_line = 1'b0;
        if (cfg.trig) begin
            st_d.pending = 1'b0;
            req_line     = active && !st_q.rirr && !cfg.mask;
        end else begin
            if (grant_ack)
                st_d.pending = 1'b0;
            if (active && !st_q.prev_act && !cfg.mask)
                st_d.pending = 1'b1;
            req_line = st_q.pending && !cfg.mask;
        end
        if (eoi_valid && cfg.trig && (eoi_vector == cfg.vector))
            st_d.rirr = 1'b0;
        if (grant_ack && cfg.trig)
            st_d.rirr = 1'b1;
        dstat = req_line;
        rirr  = st_q.rirr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    rirr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rirr) |-> $past(grant_ack));

    // R9
    rirr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.rirr) |-> $past(eoi_valid));

endmodule

// File: rtl/irq_window_regs.sv
module irq_window_regs
    import irq_redir_pkg::*;
#(
    parameter int         NPINS   = 24,
    parameter logic [7:0] VERSION = 8'h11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [7:0]             bus_addr,
    input  logic                   bus_wr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NPINS-1:0]       dstat,
    input  logic [NPINS-1:0]       rirr,
    output entry_cfg_t [NPINS-1:0] cfg
);

    localparam int         IW      = (NPINS > 1) ? $clog2(NPINS) : 1;
    localparam logic [7:0] TBL_END = 8'(16 + 2 * NPINS);
    localparam logic [31:0] VER_WORD = {8'h00, 8'(NPINS - 1), 8'h00, VERSION};

    typedef struct packed {
        logic [7:0]             sel;
        logic [3:0]             id;
        entry_cfg_t [NPINS-1:0] cfg;
    } win_state_t;

    win_state_t      st_d, st_q;
    logic            in_tbl;
    logic            hi_half;
    logic [IW-1:0]   ent;
    logic [31:0]     win_rd;
    logic            unused_wbits;

    assign unused_wbits = ^{bus_wdata[23:17], bus_wdata[14], bus_wdata[12]};

    always_comb begin
        st_d    = st_q;
        in_tbl  = (st_q.sel >= IDX_TBL) && (st_q.sel < TBL_END);
        hi_half = st_q.sel[0];
        ent     = IW'(st_q.sel[7:1] - 7'h08);
        win_rd  = '0;
        if (in_tbl) begin
            if (hi_half)
                win_rd = {st_q.cfg[ent].dest, 24'h0};
            else
                win_rd = {15'h0, st_q.cfg[ent].mask, st_q.cfg[ent].trig, rirr[ent],
                          st_q.cfg[ent].pol, dstat[ent], st_q.cfg[ent].dlog,
                          st_q.cfg[ent].dmode, st_q.cfg[ent].vector};
        end else begin
            case (st_q.sel)
                IDX_ID, IDX_ARB: win_rd = {4'h0, st_q.id, 24'h0};
                IDX_VER:         win_rd = VER_WORD;
                default:         win_rd = '0;
            endcase
        end

        if (bus_wr && bus_addr == ADDR_SEL) begin
            st_d.sel = bus_wdata[7:0];
        end else if (bus_wr && bus_addr == ADDR_WIN) begin
            if (in_tbl) begin
                if (hi_half) begin
                    st_d.cfg[ent].dest = bus_wdata[31:24];
                end else begin
                    st_d.cfg[ent].vector = bus_wdata[7:0];
                    st_d.cfg[ent].dmode  = bus_wdata[10:8];
                    st_d.cfg[ent].dlog   = bus_wdata[11];
                    st_d.cfg[ent].pol    = bus_wdata[13];
                    st_d.cfg[ent].trig   = bus_wdata[15];
                    st_d.cfg[ent].mask   = bus_wdata[16];
                end
            end else if (st_q.sel == IDX_ID) begin
                st_d.id = bus_wdata[27:24];
            end
        end

        case (bus_addr)
            ADDR_SEL: bus_rdata = {24'h0, st_q.sel};
            ADDR_WIN: bus_rdata = win_rd;
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < NPINS; i++)
                st_q.cfg[i].mask <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.cfg;

    // R4
    lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_WIN && in_tbl && !hi_half) |=>
        (st_q.cfg[$past(ent)].vector == $past(bus_wdata[7:0]) &&
         st_q.cfg[$past(ent)].dest == $past(st_q.cfg[ent].dest)));

endmodule

// File: rtl/irq_grant_arb.sv
module irq_grant_arb
    import irq_redir_pkg::*;
#(
    parameter int NPINS = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPINS-1:0]       req_lines,
    input  entry_cfg_t [NPINS-1:0] cfg,
    input  logic                   req_accept,
    output logic                   req_valid,
    output logic [7:0]             req_vector,
    output logic [2:0]             req_dmode,
    output logic                   req_dlogical,
    output logic [7:0]             req_dest,
    output logic [NPINS-1:0]       ack
);

    localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1;

    typedef struct packed {
        logic          valid;
        logic [IW-1:0] pin;
        logic [7:0]    vector;
        logic [2:0]    dmode;
        logic          dlog;
        logic [7:0]    dest;
    } arb_state_t;

    arb_state_t    st_d, st_q;
    logic          found;
    logic [IW-1:0] pick;
    logic          unused_cfg;

    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < NPINS; i++)
            acc = acc ^ cfg[i].mask ^ cfg[i].trig ^ cfg[i].pol;
        unused_cfg = acc;
    end

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NPINS - 1; i >= 0; i--) begin
            if (req_lines[i]) begin
                found = 1'b1;
                pick  = IW'(i);
            end
        end

        st_d = st_q;
        ack  = '0;
        if (st_q.valid) begin
            if (req_accept) begin
                st_d.valid   = 1'b0;
                ack[st_q.pin] = 1'b1;
            end
        end else if (found) begin
            st_d.valid  = 1'b1;
            st_d.pin    = pick;
            st_d.vector = cfg[pick].vector;
            st_d.dmode  = cfg[pick].dmode;
            st_d.dlog   = cfg[pick].dlog;
            st_d.dest   = cfg[pick].dest;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_valid    = st_q.valid;
    assign req_vector   = st_q.vector;
    assign req_dmode    = st_q.dmode;
    assign req_dlogical = st_q.dlog;
    assign req_dest     = st_q.dest;

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && !req_accept) |=>
        (st_q.valid && $stable(st_q.vector) && $stable(st_q.pin) && $stable(st_q.dest)));

    // R10
    priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.valid) |->
        (($past(req_lines) & (NPINS'(1) << st_q.pin)) != '0 &&
         ($past(req_lines) & ((NPINS'(1) << st_q.pin) - NPINS'(1))) == '0));

endmodule

// File: rtl/irq_redirect_unit.sv
module irq_redirect_unit
    import irq_redir_pkg::*;
#(
    parameter int         NPINS   = 24,
    parameter logic [7:0] VERSION = 8'h11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [NPINS-1:0] irq_pins,
    output logic             req_valid,
    input  logic             req_accept,
    output logic [7:0]       req_vector,
    output logic [2:0]       req_dmode,
    output logic             req_dlogical,
    output logic [7:0]       req_dest,
    input  logic             eoi_valid,
    input  logic [7:0]       eoi_vector
);

    entry_cfg_t [NPINS-1:0] cfg;
    logic [NPINS-1:0] req_lines, dstat, rirr, ack;

    irq_window_regs #(.NPINS(NPINS), .VERSION(VERSION)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dstat(dstat), .rirr(rirr), .cfg(cfg)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        irq_pin_slice u_slice (
            .clk(clk), .rst_n(rst_n), .pin_in(irq_pins[g]), .cfg(cfg[g]),
            .grant_ack(ack[g]), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
            .req_line(req_lines[g]), .dstat(dstat[g]), .rirr(rirr[g])
        );
    end

    irq_grant_arb #(.NPINS(NPINS)) u_arb (
        .clk(clk), .rst_n(rst_n), .req_lines(req_lines), .cfg(cfg),
        .req_accept(req_accept), .req_valid(req_valid), .req_vector(req_vector),
        .req_dmode(req_dmode), .req_dlogical(req_dlogical), .req_dest(req_dest),
        .ack(ack)
    );

endmodule

// File: tb/test_irq_redirect_unit.sv
module test_irq_redirect_unit;

    localparam int NP = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] irq_pins = '0;
    logic        req_valid;
    logic        req_accept = 1'b0;
    logic [7:0]  req_vector;
    logic [2:0]  req_dmode;
    logic        req_dlogical;
    logic [7:0]  req_dest;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_redirect_unit i_irq_redirect_unit (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pins(irq_pins),
        .req_valid(req_valid), .req_accept(req_accept), .req_vector(req_vector),
        .req_dmode(req_dmode), .req_dlogical(req_dlogical), .req_dest(req_dest),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_addr = addr; bus_wdata = data; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic win_write(input logic [7:0] idx, input logic [31:0] data);
        bus_write(8'h00, {24'h0, idx});
        bus_write(8'h10, data);
    endtask

    task automatic win_read(input logic [7:0] idx, output logic [31:0] data);
        bus_write(8'h00, {24'h0, idx});
        bus_addr = 8'h10;
        #1 data = bus_rdata;
    endtask

    task automatic accept_one();
        @(negedge clk) req_accept = 1'b1;
        @(negedge clk) req_accept = 1'b0;
    endtask

    task automatic t_reset_and_ids();
        logic [31:0] v;
        win_read(8'h10, v);           check("R3 entry0 low", v, 32'h0001_0000);
        win_read(8'h3F, v);           check("R3 entry23 high", v, 32'h0);
        win_read(8'h01, v);           check("R2 version", v, 32'h0017_0011);
        bus_addr = 8'h00; #1;         check("R1 select readback", bus_rdata, 32'h01);
        bus_addr = 8'h08; #1;         check("R1 other address", bus_rdata, 32'h0);
        win_write(8'h00, 32'hFFFF_FFFF);
        win_read(8'h00, v);           check("R2 id", v, 32'h0F00_0000);
        win_read(8'h02, v);           check("R2 arbitration", v, 32'h0F00_0000);
    endtask

    task automatic t_halves_and_ro();
        logic [31:0] v;
        win_write(8'h10 + 8'd21, 32'hA5FF_FFFF);     // entry 10 high
        win_read(8'h10 + 8'd21, v);  check("R4 high write", v, 32'hA500_0000);
        win_read(8'h10 + 8'd20, v);  check("R4 low untouched", v, 32'h0001_0000);
        win_write(8'h10 + 8'd20, 32'h0001_00AB);
        win_read(8'h10 + 8'd21, v);  check("R4 high untouched", v, 32'hA500_0000);
        win_write(8'h10 + 8'd18, 32'h0001_5055);     // entry 9, status bits set
        win_read(8'h10 + 8'd18, v);  check("R5 read-only bits", v, 32'h0001_0055);
        win_write(8'h03, 32'hFFFF_FFFF);
        win_read(8'h03, v);          check("R5 unimplemented 0x03", v, 32'h0);
        win_write(8'h40, 32'hFFFF_FFFF);
        win_read(8'h40, v);          check("R5 past table end", v, 32'h0);
        win_read(8'h10 + 8'd47, v);  check("R5 last entry unchanged", v, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        win_write(8'h10 + 8'd7, 32'h5A00_0000);      // entry 3 dest
        win_write(8'h10 + 8'd6, 32'h0000_0C43);      // vec 43, NMI, logical
        @(negedge clk) irq_pins[3] = 1'b1;
        @(negedge clk) check("R7 not yet valid", {31'h0, req_valid}, 32'h0);
        @(negedge clk) check("R7 valid", {31'h0, req_valid}, 32'h1);
        check("R7 fields", {req_dest, 12'h0, req_dlogical, req_dmode, req_vector},
              {8'h5A, 12'h0, 1'b1, 3'd4, 8'h43});
        win_read(8'h10 + 8'd6, v);   check("R11 status pending", v, 32'h0000_1C43);
        accept_one();
        check("R7 drop after accept", {31'h0, req_valid}, 32'h0);
        win_read(8'h10 + 8'd6, v);   check("R11 status idle", v, 32'h0000_0C43);
        repeat (3) @(negedge clk);
        check("R7 single request per edge", {31'h0, req_valid}, 32'h0);
        irq_pins[3] = 1'b0;
    endtask

    task automatic t_mask();
        win_write(8'h10 + 8'd14, 32'h0001_0047);     // entry 7 masked
        @(negedge clk) irq_pins[7] = 1'b1;
        repeat (3) @(negedge clk);
        check("R6 masked no request", {31'h0, req_valid}, 32'h0);
        irq_pins[7] = 1'b0;
        win_write(8'h10 + 8'd14, 32'h0000_0047);
        repeat (3) @(negedge clk);
        check("R6 stale edge dropped", {31'h0, req_valid}, 32'h0);
    endtask

    task automatic t_polarity();
        @(negedge clk) irq_pins[5] = 1'b1;
        win_write(8'h10 + 8'd10, 32'h0000_2055);     // entry 5 active low
        repeat (2) @(negedge clk);
        check("R8 idle high", {31'h0, req_valid}, 32'h0);
        irq_pins[5] = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 falling fires", {24'h0, req_vector} | {23'h0, req_valid, 8'h0},
              32'h0000_0155);
        accept_one();
        irq_pins[5] = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 rising silent", {31'h0, req_valid}, 32'h0);
    endtask

    task automatic t_priority();
        win_write(8'h10 + 8'd2, 32'h0000_0031);
        win_write(8'h10 + 8'd4, 32'h0000_0032);
        @(negedge clk) irq_pins[2:1] = 2'b11;
        repeat (2) @(negedge clk);
        check("R10 lowest first", {23'h0, req_valid, req_vector}, 32'h0000_0131);
        @(negedge clk) check("R10 held", {23'h0, req_valid, req_vector}, 32'h0000_0131);
        accept_one();
        check("R10 gap", {31'h0, req_valid}, 32'h0);
        @(negedge clk) check("R10 next pin", {23'h0, req_valid, req_vector}, 32'h0000_0132);
        accept_one();
        irq_pins[2:1] = 2'b00;
    endtask

    task automatic t_level();
        logic [31:0] v;
        win_write(8'h10 + 8'd40, 32'h0000_8060);     // entry 20 level
        @(negedge clk) irq_pins[20] = 1'b1;
        @(negedge clk) check("R9 level request", {23'h0, req_valid, req_vector}, 32'h0000_0160);
        accept_one();
        repeat (3) @(negedge clk);
        check("R9 blocked by rirr", {31'h0, req_valid}, 32'h0);
        win_read(8'h10 + 8'd40, v);  check("R9 rirr set", v, 32'h0000_C060);
        @(negedge clk) begin eoi_valid = 1'b1; eoi_vector = 8'h61; end
        @(negedge clk) eoi_valid = 1'b0;
        @(negedge clk) check("R9 wrong eoi ignored", {31'h0, req_valid}, 32'h0);
        win_read(8'h10 + 8'd40, v);  check("R9 rirr kept", v, 32'h0000_C060);
        @(negedge clk) begin eoi_valid = 1'b1; eoi_vector = 8'h60; end
        @(negedge clk) begin
            eoi_valid = 1'b0;
            check("R9 not before re-arm", {31'h0, req_valid}, 32'h0);
        end
        @(negedge clk) check("R9 re-request", {23'h0, req_valid, req_vector}, 32'h0000_0160);
        accept_one();
        irq_pins[20] = 1'b0;
        @(negedge clk) begin eoi_valid = 1'b1; eoi_vector = 8'h60; end
        @(negedge clk) eoi_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 inactive pin quiet", {31'h0, req_valid}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk) check("R3 no request after reset", {31'h0, req_valid}, 32'h0);
        t_reset_and_ids();
        t_halves_and_ro();
        t_edge();
        t_mask();
        t_polarity();
        t_priority();
        t_level();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule